// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the slave side of a byte-addressed serial EEPROM on a two-wire bus. It runs in the system clock domain. It oversamples the bus clock and data lines, finds start and stop conditions, and decodes the device address word. It acknowledges by pulling the data line low through an open-drain enable. The storage is a register array of 256, 512, 1024 or 2048 bytes, chosen by parameter. Writes collect into a page buffer. The stop condition that ends a write commits the buffer to the array and starts a self-timed busy period.

A bus master performs byte writes, page writes, current address reads, random reads (a dummy write that loads the word address, then a repeated start) and sequential reads. During the busy period the block answers nothing. A master can therefore poll the device address until it sees an acknowledge. A write-protect input keeps the array from changing while data transfers still complete normally.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset, and from the cycle after any stop condition, the block does not drive the data line. A start condition (data falling while clock is high) always restarts reception of a device address word, unless the block is busy.
- R2: The device address word is accepted only if its upper four bits are 1010 and its pin-compared bits match `pinAddr`. Bit 0 set means read, clear means write. On a mismatch the block gives no acknowledge and ignores all bytes until the next start.
- R3: Device address bits 3..1 are compared with `pinAddr[2:0]` at 256 bytes. At 512 bytes, bits 3..2 are compared and bit 1 is memory address bit 8. At 1024 bytes, bit 3 is compared and bits 2..1 are address bits 9..8. At 2048 bytes, bits 3..1 are address bits 10..8 and no pins are compared.
- R4: Every byte that a matched write transfer receives (device address, word address, data) is acknowledged by holding the data line low through the ninth clock pulse.
- R5: A byte write (device address, word address, one data byte, stop) stores the byte at that address. A later read returns it.
- R6: A page write stores its data bytes at consecutive addresses. The low address bits (3 bits at 256 bytes, 4 bits otherwise) wrap inside the page. A later byte overwrites an earlier one at the same offset. Nothing is written before the stop.
- R7: A read returns successive bytes while the master acknowledges each one. The address wraps from the last byte of the array to address 0. After a byte that is not acknowledged, the block releases the line.
- R8: A read started without a word address returns the byte at the last accessed address plus one.
- R9: For `WR_CYCLES` clocks after a committing stop, the block ignores all traffic and does not acknowledge its device address. Afterwards it acknowledges again.
- R10: While `wrProt` is high at the stop, data bytes are still acknowledged but the array is not modified. The busy period still runs.
- R11: A write transfer that ends with a repeated start instead of a stop commits nothing and starts no busy period.
- R12: The block changes its data-line drive only after a falling bus clock edge, or on a start or stop. Its read data is therefore stable while the bus clock is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line, sampled |
| sdaIn | input | 1 | Bus data line, sampled |
| pinAddr | input | 3 | Hardwired device select pins |
| wrProt | input | 1 | Write protect, high blocks array updates |
| sdaOe | output | 1 | Open-drain enable: 1 pulls the data line low |

## Verification
The bench aims at the page wrap, the array wrap during sequential reads, and the current-address pointer left behind by a read. A design that incremented the full address during page writes would spill data into the next page. A design that stopped at the array end would return wrong bytes after address 0xFF. It also polls right after a commit and right after an aborted write. A missing busy lockout would acknowledge the first poll too early, and a commit on repeated start would both lock out the second poll and change the stored byte. The protected write checks that the acknowledges still come while the old data survives. A second instance at 2048 bytes proves that the device address bits select separate storage rows.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_WADR,
    S_WDAT,
    S_RD,
    S_RACK
  } busState_t;

  typedef struct packed {
    logic latchDev;
    logic loadAddr;
    logic pushData;
    logic commit;
    logic stepRead;
  } dpCmd_t;

endpackage

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] pinAddr,
  input  logic       busy,
  input  logic [7:0] rdByte,
  output dpCmd_t     cmd,
  output logic [7:0] rxByte,
  output logic       sdaOe
);
  localparam int HI_BITS = ADDR_W - 8;
  localparam logic [2:0] PIN_MASK = 3'(7 << HI_BITS);

  logic [1:0] sclSync, sdaSync;
  logic       sclPrev, sdaPrev;
  logic       sclNow, sdaNow, sclRise, sclFall, startDet, stopDet;
  busState_t  state;
  logic [3:0] bitCnt;
  logic [7:0] shiftReg;
  logic       ackDrive, rdDrive, isRead, masterAck, dataSeen, devMatch;
  logic [2:0] nextIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclSync[1];
      sdaPrev <= sdaSync[1];
    end
  end

  assign sclNow   = sclSync[1];
  assign sdaNow   = sdaSync[1];
  assign sclRise  = sclNow & ~sclPrev;
  assign sclFall  = ~sclNow & sclPrev;
  assign startDet = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopDet  = sclNow & sclPrev & ~sdaPrev & sdaNow;
  assign devMatch = (shiftReg[7:4] == 4'b1010) &&
                    (((shiftReg[3:1] ^ pinAddr) & PIN_MASK) == 3'b000);
  assign nextIdx  = 3'd6 - bitCnt[2:0];
  assign rxByte   = shiftReg;
  assign sdaOe    = ackDrive | rdDrive;

  always_comb begin
    cmd = '0;
    if (stopDet && state == S_WDAT && dataSeen) cmd.commit = 1'b1;
    if (sclFall && !ackDrive && bitCnt == 4'd8) begin
      case (state)
        S_DEV:   cmd.latchDev = devMatch;
        S_WADR:  cmd.loadAddr = 1'b1;
        S_WDAT:  cmd.pushData = 1'b1;
        default: ;
      endcase
    end
    if (sclFall && state == S_RD && bitCnt == 4'd7) cmd.stepRead = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      bitCnt    <= '0;
      shiftReg  <= '0;
      ackDrive  <= 1'b0;
      rdDrive   <= 1'b0;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
      dataSeen  <= 1'b0;
    end else if (startDet && !busy) begin
      state    <= S_DEV;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      rdDrive  <= 1'b0;
      dataSeen <= 1'b0;
    end else if (stopDet) begin
      state    <= S_IDLE;
      ackDrive <= 1'b0;
      rdDrive  <= 1'b0;
    end else begin
      case (state)
        S_DEV, S_WADR, S_WDAT: begin
          if (sclRise && !ackDrive && bitCnt != 4'd8) begin
            shiftReg <= {shiftReg[6:0], sdaNow};
            bitCnt   <= bitCnt + 4'd1;
          end else if (sclFall && ackDrive) begin
            ackDrive <= 1'b0;
            bitCnt   <= '0;
            if (state == S_DEV && isRead) begin
              state   <= S_RD;
              rdDrive <= ~rdByte[7];
            end else if (state == S_DEV) begin
              state <= S_WADR;
            end else begin
              state <= S_WDAT;
            end
          end else if (sclFall && bitCnt == 4'd8) begin
            if (state != S_DEV || devMatch) ackDrive <= 1'b1;
            else state <= S_IDLE;
            if (state == S_DEV) isRead <= shiftReg[0];
            if (state == S_WDAT) dataSeen <= 1'b1;
          end
        end
        S_RD: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              rdDrive <= 1'b0;
              state   <= S_RACK;
            end else begin
              bitCnt  <= bitCnt + 4'd1;
              rdDrive <= ~rdByte[nextIdx];
            end
          end
        end
        S_RACK: begin
          if (sclRise) begin
            masterAck <= ~sdaNow;
          end else if (sclFall) begin
            if (masterAck) begin
              state   <= S_RD;
              bitCnt  <= '0;
              rdDrive <= ~rdByte[7];
            end else begin
              state <= S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  AST_QUIET_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOe); // R9
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaOe); // R1
  AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> $past(sclFall || startDet || stopDet)); // R12
  AST_NO_ACK_MISMATCH: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DEV && sclFall && !ackDrive && bitCnt == 4'd8 && !devMatch)
      |=> !sdaOe); // R2

endmodule

// File: rtl/eeprom_dp.sv
module eeprom_dp
  import eeprom_pkg::*;
#(
  parameter int MEM_BYTES  = 256,
  parameter int PAGE_BYTES = 8,
  parameter int WR_CYCLES  = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpCmd_t     cmd,
  input  logic [7:0] rxByte,
  input  logic       wrProt,
  output logic [7:0] rdByte,
  output logic       busy
);
  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam int PG_W   = $clog2(PAGE_BYTES);
  localparam int CNT_W  = $clog2(WR_CYCLES + 1);

  logic [7:0]             mem     [MEM_BYTES];
  logic [7:0]             pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]  pageVal;
  logic [ADDR_W-1:0]      addrCnt;
  logic [2:0]             devHi;
  logic [CNT_W-1:0]       busyCnt;
  logic [PG_W-1:0]        offs;
  logic [ADDR_W-PG_W-1:0] pageSel;

  assign offs    = addrCnt[PG_W-1:0];
  assign pageSel = addrCnt[ADDR_W-1:PG_W];
  assign rdByte  = mem[addrCnt];
  assign busy    = (busyCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrCnt <= '0;
      devHi   <= '0;
      pageVal <= '0;
      busyCnt <= '0;
    end else begin
      if (cmd.latchDev) devHi <= rxByte[3:1];
      if (cmd.loadAddr) begin
        addrCnt <= ADDR_W'({devHi, rxByte});
        pageVal <= '0;
      end
      if (cmd.pushData) begin
        pageVal[offs]         <= 1'b1;
        addrCnt[PG_W-1:0]     <= offs + 1'b1;
      end
      if (cmd.stepRead) addrCnt <= addrCnt + 1'b1;
      if (cmd.commit) busyCnt <= CNT_W'(WR_CYCLES);
      else if (busy) busyCnt <= busyCnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (cmd.pushData) pageBuf[offs] <= rxByte;
    if (cmd.commit && !wrProt) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (pageVal[i]) mem[{pageSel, PG_W'(i)}] <= pageBuf[i];
      end
    end
  end

  AST_PAGE_ROW_HELD: assert property (@(posedge clk) disable iff (!rstN)
    cmd.pushData |=> $stable(pageSel)); // R6
  AST_READ_WRAPS: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.stepRead && addrCnt == {ADDR_W{1'b1}}) |=> (addrCnt == '0)); // R7
  AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmd.commit)); // R9

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import eeprom_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  parameter int WR_CYCLES = 250000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] pinAddr,
  input  logic       wrProt,
  output logic       sdaOe
);
  localparam int ADDR_W     = $clog2(MEM_BYTES);
  localparam int PAGE_BYTES = (MEM_BYTES <= 256) ? 8 : 16;

  dpCmd_t     cmd;
  logic [7:0] rxByte, rdByte;
  logic       busy;

  eeprom_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .pinAddr(pinAddr), .busy(busy), .rdByte(rdByte),
    .cmd(cmd), .rxByte(rxByte), .sdaOe(sdaOe)
  );

  eeprom_dp #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES),
              .WR_CYCLES(WR_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .rxByte(rxByte),
    .wrProt(wrProt), .rdByte(rdByte), .busy(busy)
  );

endmodule

// File: tb/tb_serial_eeprom_slave.sv
module tb_serial_eeprom_slave;
  localparam int WRC = 400;
  localparam int Q   = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, sel2 = 1'b0, wrProt = 1'b0;
  logic oe1, oe2;
  wire  sdaBus = sdaM & ~oe1 & ~oe2;
  wire  sda1 = sel2 ? 1'b1 : sdaBus;
  wire  sda2 = sel2 ? sdaBus : 1'b1;

  always #10 clk = ~clk;

  serial_eeprom_slave #(.MEM_BYTES(256), .WR_CYCLES(WRC)) dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sda1),
    .pinAddr(3'b101), .wrProt(wrProt), .sdaOe(oe1));
  serial_eeprom_slave #(.MEM_BYTES(2048), .WR_CYCLES(WRC)) dut2 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sda2),
    .pinAddr(3'b000), .wrProt(wrProt), .sdaOe(oe2));

  int nChecks = 0, nErr = 0;
  bit done = 1'b0;
  logic [7:0] expVal[$];
  string      expTag[$];
  logic [7:0] wrData[$];
  logic [7:0] gotByte;
  event       rxEv;

  task automatic check(bit ok, string tag, int act, int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", nChecks, nErr);
      $finish;
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q);
    sdaM = 1'b0; tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(Q); sclM = 1'b1; tick(Q); sdaM = 1'b1; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; tick(Q); sclM = 1'b1; tick(Q); sclM = 1'b0; tick(Q);
    end
    sdaM = 1'b1; tick(Q); sclM = 1'b1; tick(Q / 2);
    acked = ~sdaBus;
    tick(Q / 2); sclM = 1'b0; tick(Q);
  endtask

  task automatic recvByte(input logic ackIt);
    logic [7:0] b;
    logic steady;
    steady = 1'b1;
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); sclM = 1'b1; tick(Q / 2);
      b[i] = sdaBus;
      tick(Q / 2 - 1);
      if (sdaBus != b[i]) steady = 1'b0;
      tick(1); sclM = 1'b0;
    end
    check(steady, "R12", steady, 1);
    tick(Q); sdaM = ~ackIt; tick(Q);
    sclM = 1'b1; tick(Q); sclM = 1'b0; tick(Q);
    gotByte = b;
    ->rxEv;
  endtask

  task automatic expectByte(logic [7:0] v, string tag);
    expVal.push_back(v);
    expTag.push_back(tag);
  endtask

  // monitor: pops the expected stream as bytes come back
  initial begin
    forever begin
      @(rxEv);
      if (expVal.size() == 0) check(1'b0, "SCOREBOARD", gotByte, 0);
      else check(gotByte == expVal[0], expTag[0], gotByte, expVal[0]);
      if (expVal.size() != 0) begin
        void'(expVal.pop_front());
        void'(expTag.pop_front());
      end
    end
  end

  task automatic writeBytes(logic [7:0] dev, logic [7:0] wa, string tag);
    logic a;
    busStart();
    sendByte(dev, a); check(a, tag, a, 1);
    sendByte(wa, a);  check(a, tag, a, 1);
    foreach (wrData[k]) begin
      sendByte(wrData[k], a); check(a, tag, a, 1);
    end
    busStop();
  endtask

  task automatic randRead(logic [7:0] dev, logic [7:0] wa, int n);
    logic a;
    busStart();
    sendByte(dev & 8'hFE, a); check(a, "R7", a, 1);
    sendByte(wa, a);          check(a, "R7", a, 1);
    busStart();
    sendByte(dev | 8'h01, a); check(a, "R7", a, 1);
    for (int k = 0; k < n; k++) recvByte(k != n - 1);
    busStop();
    check(sdaBus == 1'b1, "R1", sdaBus, 1);
  endtask

  initial begin
    logic a;
    tick(5);
    check(oe1 == 1'b0 && oe2 == 1'b0, "R1", oe1, 0);
    rstN = 1'b1;
    tick(5);

    // R2: wrong pins, then later bytes ignored
    busStart();
    sendByte(8'hA2, a); check(!a, "R2", a, 0);
    sendByte(8'h10, a); check(!a, "R2", a, 0);
    busStop();

    // R5 byte write, R9 busy poll
    wrData = '{8'h5A};
    writeBytes(8'hAA, 8'h10, "R4");
    busStart(); sendByte(8'hAA, a); check(!a, "R9", a, 0); busStop();
    tick(WRC + 50);
    busStart(); sendByte(8'hAA, a); check(a, "R9", a, 1); busStop();
    expectByte(8'h5A, "R5");
    randRead(8'hAA, 8'h10, 1);

    // R6 page write wrapping inside page 0x18..0x1F
    wrData = '{8'h30, 8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    writeBytes(8'hAA, 8'h1E, "R4");
    tick(WRC + 50);
    for (int k = 0; k < 8; k++) expectByte(8'h32 + 8'(k), "R6");
    randRead(8'hAA, 8'h18, 8);

    // R7 array wrap on sequential read, R8 current address
    wrData = '{8'h11, 8'h22};
    writeBytes(8'hAA, 8'h00, "R4");
    tick(WRC + 50);
    wrData = '{8'hEE, 8'hFF};
    writeBytes(8'hAA, 8'hFE, "R4");
    tick(WRC + 50);
    expectByte(8'hEE, "R7"); expectByte(8'hFF, "R7"); expectByte(8'h11, "R7");
    randRead(8'hAA, 8'hFE, 3);
    expectByte(8'h22, "R8");
    busStart(); sendByte(8'hAB, a); check(a, "R8", a, 1);
    recvByte(1'b0); busStop();

    // R10 protected write
    wrProt = 1'b1;
    wrData = '{8'h99};
    writeBytes(8'hAA, 8'h10, "R10");
    tick(WRC + 50);
    wrProt = 1'b0;
    expectByte(8'h5A, "R10");
    randRead(8'hAA, 8'h10, 1);

    // R11 aborted write by repeated start
    busStart();
    sendByte(8'hAA, a); sendByte(8'h10, a); sendByte(8'h77, a);
    check(a, "R11", a, 1);
    busStart(); busStop();
    busStart(); sendByte(8'hAA, a); check(a, "R11", a, 1); busStop();
    expectByte(8'h5A, "R11");
    randRead(8'hAA, 8'h10, 1);

    // R3 large array: device bits select rows
    sel2 = 1'b1;
    wrData = '{8'h3C};
    writeBytes(8'hA6, 8'h45, "R3");
    tick(WRC + 50);
    wrData = '{8'hC3};
    writeBytes(8'hA0, 8'h45, "R3");
    tick(WRC + 50);
    expectByte(8'h3C, "R3");
    randRead(8'hA6, 8'h45, 1);
    expectByte(8'hC3, "R3");
    randRead(8'hA0, 8'h45, 1);
    sel2 = 1'b0;

    tick(20);
    check(expVal.size() == 0, "SCOREBOARD", expVal.size(), 0);
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    finishRun();
  end

endmodule